// File: doc/BRIEF.md
# GPIO Port with Data-Driven Pull-ups

This block is an eight-pin general-purpose I/O port controlled over a small synchronous register bus. A direction register selects, pin by pin, whether the pin drives or listens. A single data register serves both cases. For a driving pin, its bit is the level put on the pin. For a listening pin, the same bit switches that pin's weak pull-up on or off. Reading the port address does not return the data register. It returns a blend: each listening bit shows the synchronized level on the pin, and each driving bit shows the stored data bit.

The port also takes single-bit set and clear commands. Each command is carried out as a read-modify-write of the port. The sequencer samples the blended port value, merges in the selected bit, and writes the whole byte back into the data register. Because listening bits are read from the pins, the write-back can replace their stored bits with the pin levels. That silently reverses pull-up settings on pins the command never named. The block keeps this behaviour on purpose, so that the effect can be seen. Raw read-back addresses for both registers let the disturbance be observed directly.

Top module: `gpio_pullup_port`

## Requirements
- R1: A direction bit of 1 makes its pin a driver (`pin_oe` bit 1); a direction bit of 0 makes it an input (`pin_oe` bit 0).
- R2: A bus write to address 0 stores all eight bits into the data register, whatever the direction bits are. The new value is visible from the clock edge that samples `wr_en`.
- R3: A read of address 0 returns, for each bit, the data register bit when the direction bit is 1 and the pin level when it is 0. The pin level passes through two flops, so a pin change first shows after the second rising edge.
- R4: On an input pin, `pull_en` equals the data bit. On a driving pin, `pull_en` is 0 and `pin_out` equals the data bit. `pin_out` is 0 on input pins.
- R5: A set command (`cmd_valid` with `cmd_set`=1, bit index `cmd_bit`) makes `busy` rise after the accepting edge and stay high for exactly two cycles. The port value is sampled in the first busy cycle, the selected bit is ORed in, and the whole byte is written to the data register at the end of the second busy cycle.
- R6: A clear command (`cmd_set`=0) behaves like R5, except that the sampled port value is ANDed with the inverted one-bit mask.
- R7: While `busy` is high, bus writes to any address and new commands are ignored.
- R8: Reset clears the direction and data registers. Every pin is then an input, with `pull_en` 0, `pin_out` 0 and `busy` 0.
- R9: A read of address 1 returns the raw direction register, a read of address 2 returns the raw data register, and a read of address 3 returns 0. Writes to addresses 2 and 3 change nothing.
- R10: Start with the data register at 0x80 and direction 0x3F, with pin 7 low, pin 6 high and all other pins low. The port reads 0x40. A set of bit 0 then leaves the data register at 0x41, `pin_out` at 0x01 and `pull_en` at 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 2 | Register address: 0 port/data, 1 direction, 2 raw data, 3 none |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data for `addr` (combinational) |
| cmd_valid | input | 1 | Start a single-bit read-modify-write |
| cmd_set | input | 1 | 1 sets the bit, 0 clears it |
| cmd_bit | input | 3 | Index of the bit to change |
| busy | output | 1 | Read-modify-write in progress |
| pin_in | input | 8 | Levels sensed on the pins |
| pin_out | output | 8 | Levels driven on the pins |
| pin_oe | output | 8 | Per-pin drive enable |
| pull_en | output | 8 | Per-pin weak pull-up enable |

## Verification
The bench goes first for the pull-up disturbance. It runs a set command with input pins whose levels differ from their stored bits, then checks that the data register takes the pin levels and that `pull_en` flips on the untouched pins. A design that wrote back only the target bit, or that read the raw register, would leave the pull-ups alone. The bench times the two-flop pin latency, checking the port read after one edge and again after two. A missing or extra synchronizer stage would show the new level one cycle early or late. It also writes to both registers in the middle of a command to confirm that the writes are dropped, and it compares clear commands against the inverted mask. Random traffic is checked against a behavioural model on every cycle.

// File: rtl/gpio_pullup_pkg.sv
package gpio_pullup_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_e;

  localparam logic [1:0] ADR_PORT = 2'd0;
  localparam logic [1:0] ADR_DIR  = 2'd1;
  localparam logic [1:0] ADR_RAW  = 2'd2;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = d;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pullup_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         rmw_we,
  input  logic [W-1:0] rmw_data,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] dat_q,
  output logic [W-1:0] port_val,
  output logic [W-1:0] rdata
);
  logic [W-1:0] dir_d;
  logic [W-1:0] dat_d;
  logic         dir_en;
  logic         dat_en;

  always_comb begin
    dir_en = wr_en && (addr == ADR_DIR);
    dat_en = rmw_we || (wr_en && (addr == ADR_PORT));
    dir_d  = wdata;
    dat_d  = rmw_we ? rmw_data : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (dat_en) dat_q <= dat_d;
    end
  end

  always_comb port_val = (dir_q & dat_q) | (~dir_q & pin_sync);

  always_comb begin
    unique case (addr)
      ADR_PORT: rdata = port_val;
      ADR_DIR:  rdata = dir_q;
      ADR_RAW:  rdata = dat_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_rmw_seq.sv
module gpio_rmw_seq
  import gpio_pullup_pkg::*;
#(
  parameter int W  = 8,
  localparam int BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_set,
  input  logic [BW-1:0] cmd_bit,
  input  logic [W-1:0]  port_val,
  output logic          busy,
  output logic          rmw_we,
  output logic [W-1:0]  rmw_data
);
  seq_state_e   state_q, state_d;
  logic         set_q, set_d;
  logic [W-1:0] mask_q, mask_d;
  logic [W-1:0] tmp_q, tmp_d;
  logic         tmp_en;

  always_comb begin
    state_d = state_q;
    set_d   = set_q;
    mask_d  = mask_q;
    tmp_d   = set_q ? (port_val | mask_q) : (port_val & ~mask_q);
    tmp_en  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: if (cmd_valid) begin
        state_d = SEQ_READ;
        set_d   = cmd_set;
        mask_d  = W'(1) << cmd_bit;
      end
      SEQ_READ: begin
        state_d = SEQ_WRITE;
        tmp_en  = 1'b1;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      set_q   <= 1'b0;
      mask_q  <= '0;
      tmp_q   <= '0;
    end else begin
      state_q <= state_d;
      set_q   <= set_d;
      mask_q  <= mask_d;
      if (tmp_en) tmp_q <= tmp_d;
    end
  end

  assign busy     = (state_q != SEQ_IDLE);
  assign rmw_we   = (state_q == SEQ_WRITE);
  assign rmw_data = tmp_q;
endmodule

// File: rtl/gpio_pullup_port.sv
module gpio_pullup_port #(
  parameter int W  = 8,
  localparam int BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          cmd_valid,
  input  logic          cmd_set,
  input  logic [BW-1:0] cmd_bit,
  output logic          busy,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pull_en
);
  logic         srst_n;
  logic [W-1:0] pin_sync;
  logic [W-1:0] dir_q;
  logic [W-1:0] dat_q;
  logic [W-1:0] port_val;
  logic         rmw_we;
  logic [W-1:0] rmw_data;
  logic         bus_we;

  assign bus_we = wr_en && !busy;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  gpio_in_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(srst_n), .d(pin_in), .q(pin_sync)
  );

  gpio_port_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(bus_we), .addr(addr), .wdata(wdata),
    .rmw_we(rmw_we), .rmw_data(rmw_data), .pin_sync(pin_sync),
    .dir_q(dir_q), .dat_q(dat_q), .port_val(port_val), .rdata(rdata)
  );

  gpio_rmw_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(srst_n), .cmd_valid(cmd_valid), .cmd_set(cmd_set),
    .cmd_bit(cmd_bit), .port_val(port_val), .busy(busy),
    .rmw_we(rmw_we), .rmw_data(rmw_data)
  );

  for (genvar i = 0; i < W; i++) begin : g_pad
    assign pin_oe[i]  = dir_q[i];
    assign pin_out[i] = dir_q[i] & dat_q[i];
    assign pull_en[i] = ~dir_q[i] & dat_q[i];
  end
endmodule

// File: rtl/gpio_pullup_port_chk.sv
module gpio_pullup_port_chk
  import gpio_pullup_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         srst_n,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic         busy,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] dat_q,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pull_en
);
  a_r4_no_pull_on_driver: assert property (@(posedge clk) disable iff (!srst_n)
    (pull_en & pin_oe) == '0);

  a_r4_no_drive_on_input: assert property (@(posedge clk) disable iff (!srst_n)
    (pin_out & ~pin_oe) == '0);

  a_r2_data_write: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy && wr_en && addr == ADR_PORT) |=> (dat_q == $past(wdata)));

  a_r7_dir_hold_busy: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && wr_en && addr == ADR_DIR) |=> $stable(dir_q));

  a_r5_busy_second: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(busy) |=> busy);

  a_r5_busy_ends: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && $past(busy)) |=> !busy);

  always @(posedge clk) begin
    if (!srst_n) begin
      a_r8_reset_clear: assert (dir_q == '0 && dat_q == '0 && !busy);
    end
  end
endmodule

bind gpio_pullup_port gpio_pullup_port_chk #(.W(W)) u_chk (
  .clk(clk), .srst_n(srst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .busy(busy), .dir_q(dir_q), .dat_q(dat_q), .pin_out(pin_out),
  .pin_oe(pin_oe), .pull_en(pull_en)
);

// File: tb/gpio_pullup_port_tb.sv
module gpio_pullup_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       cmd_valid;
  logic       cmd_set;
  logic [2:0] cmd_bit;
  logic       busy;
  logic [7:0] pin_in;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic [7:0] pull_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit model_on = 1'b0;

  always #5 clk = ~clk;

  gpio_pullup_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cmd_valid(cmd_valid), .cmd_set(cmd_set), .cmd_bit(cmd_bit),
    .busy(busy), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pull_en(pull_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [7:0] m_dir, m_dr, m_tmp, m_mask, m_p1, m_p2;
  int         m_cnt;
  bit         m_set;

  function automatic logic [7:0] m_port();
    return (m_dir & m_dr) | (~m_dir & m_p2);
  endfunction

  always @(posedge clk) begin
    if (model_on) begin
      logic [7:0] mix;
      int         old_cnt;
      mix     = m_port();
      old_cnt = m_cnt;
      if (old_cnt == 0 && wr_en) begin
        if (addr == 2'd0) m_dr = wdata;
        if (addr == 2'd1) m_dir = wdata;
      end
      if (old_cnt == 0) begin
        if (cmd_valid) begin
          m_cnt  = 2;
          m_set  = cmd_set;
          m_mask = 8'(1) << cmd_bit;
        end
      end else if (old_cnt == 2) begin
        m_tmp = m_set ? (mix | m_mask) : (mix & ~m_mask);
        m_cnt = 1;
      end else begin
        m_dr  = m_tmp;
        m_cnt = 0;
      end
      m_p2 = m_p1;
      m_p1 = pin_in;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      logic [7:0] exp_rd;
      case (addr)
        2'd0: exp_rd = m_port();
        2'd1: exp_rd = m_dir;
        2'd2: exp_rd = m_dr;
        default: exp_rd = 8'h00;
      endcase
      check("R1 pin_oe", pin_oe, m_dir);
      check("R4 pin_out", pin_out, m_dir & m_dr);
      check("R4 pull_en", pull_en, ~m_dir & m_dr);
      check("R5 busy", {7'd0, busy}, {7'd0, m_cnt != 0});
      check("R3 rdata", rdata, exp_rd);
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic command(input logic s, input logic [2:0] b);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_set = s; cmd_bit = b;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic read_at(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at %0t: actual hung expected finish", $time);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
    cmd_valid = 1'b0; cmd_set = 1'b0; cmd_bit = 3'd0; pin_in = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check("R8 pin_oe", pin_oe, 8'h00);
    check("R8 pull_en", pull_en, 8'h00);
    check("R8 pin_out", pin_out, 8'h00);
    check("R8 busy", {7'd0, busy}, 8'h00);
    read_at(2'd1, v); check("R8 raw dir", v, 8'h00);
    m_dir = 8'h00; m_dr = 8'h00; m_p1 = pin_in; m_p2 = pin_in;
    m_cnt = 0; m_tmp = 8'h00; m_mask = 8'h00; m_set = 1'b0;
    model_on = 1'b1;

    // R2/R4/R1: raw write regardless of direction
    bus_write(2'd1, 8'h0F);
    bus_write(2'd0, 8'hA5);
    read_at(2'd2, v); check("R2 raw data", v, 8'hA5);
    check("R4 pull_en", pull_en, 8'hA0);
    check("R4 pin_out", pin_out, 8'h05);
    check("R1 pin_oe", pin_oe, 8'h0F);

    // R3: two-flop pin latency
    addr = 2'd0;
    @(posedge clk); #1 pin_in = 8'h50;
    @(negedge clk); check("R3 before sync", rdata, 8'h05);
    @(negedge clk); check("R3 one edge", rdata, 8'h05);
    @(negedge clk); check("R3 two edges", rdata, 8'h55);

    // R10: pull-up disturbance by set
    bus_write(2'd1, 8'h3F);
    bus_write(2'd0, 8'h80);
    @(posedge clk); #1 pin_in = 8'h40;
    repeat (3) @(posedge clk);
    read_at(2'd0, v); check("R10 port read", v, 8'h40);
    command(1'b1, 3'd0);
    repeat (2) @(posedge clk);
    read_at(2'd2, v); check("R10 data after set", v, 8'h41);
    check("R10 pin_out", pin_out, 8'h01);
    check("R10 pull_en", pull_en, 8'h40);

    // R6: clear uses inverted mask, pins low overwrite inputs
    bus_write(2'd1, 8'h0F);
    bus_write(2'd0, 8'hFF);
    @(posedge clk); #1 pin_in = 8'h00;
    repeat (3) @(posedge clk);
    command(1'b0, 3'd1);
    repeat (2) @(posedge clk);
    read_at(2'd2, v); check("R6 data after clear", v, 8'h0D);
    check("R6 pull_en", pull_en, 8'h00);

    // R7: writes during busy ignored
    command(1'b1, 3'd7);
    #1 wr_en = 1'b1; addr = 2'd1; wdata = 8'hFF;
    @(posedge clk); #1 addr = 2'd0; wdata = 8'h00;
    @(posedge clk); #1 wr_en = 1'b0;
    read_at(2'd1, v); check("R7 dir kept", v, 8'h0F);
    read_at(2'd2, v); check("R7 data is rmw result", v, 8'h8D);

    // R9: raw reads and dead addresses
    bus_write(2'd2, 8'h11);
    bus_write(2'd3, 8'h22);
    read_at(2'd1, v); check("R9 raw dir", v, 8'h0F);
    read_at(2'd2, v); check("R9 raw data", v, 8'h8D);
    read_at(2'd3, v); check("R9 addr3", v, 8'h00);

    // Random traffic against the model (R1..R7)
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      wr_en     = ($urandom % 3) == 0;
      addr      = 2'($urandom);
      wdata     = 8'($urandom);
      cmd_valid = ($urandom % 4) == 0;
      cmd_set   = 1'($urandom);
      cmd_bit   = 3'($urandom);
      if (($urandom % 5) == 0) pin_in = 8'($urandom);
    end
    @(posedge clk); #1 wr_en = 1'b0; cmd_valid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule